// File: doc/BRIEF.md
# Serial Parameter Loader for a Sine Synthesizer

This block takes bytes from an asynchronous serial line and writes them into the two control words of a direct digital sine synthesizer: the phase-accumulator step, which sets the output frequency, and the amplitude scale, a positive Q15 number. The receiver expects a start bit, eight data bits sent least significant first, an odd parity bit and one stop bit. It oversamples each bit sixteen times and reads the bit at its centre.

Bytes take turns. After reset the first good byte is a frequency step. The next good byte is an amplitude. After that the order repeats. An amplitude byte lands in bits 14..7 of the amplitude word, so it covers the full positive Q15 range in steps of 128. A frequency byte is written zero-extended. Each write comes with a one-cycle strobe, so the synthesizer can pick up the new value. A frame with a bad parity or stop bit is dropped. It does not move the byte order forward, and it sets an error flag that stays set until reset.

Top module: `sdl_param_loader`

## Requirements
- R1: The receiver takes frames made of a low start bit, eight data bits (least significant first), an odd parity bit (the nine bits together hold an odd number of ones) and a high stop bit.
- R2: One bit lasts 16*DIV clock cycles, where DIV = round(CLK_HZ / (BAUD*16)).
- R3: After reset, freq_step_o = 500, amp_o = 16'h7FFF, err_o = 0, and the next good byte goes to the frequency step.
- R4: A good byte taken as a frequency step sets freq_step_o = {8'h00, byte} and pulses freq_upd_o high for exactly one cycle.
- R5: A good byte taken as an amplitude sets amp_o = {1'b0, byte, 7'b0000000} and pulses amp_upd_o high for exactly one cycle.
- R6: Good bytes take turns, starting with a frequency step after reset: frequency, amplitude, frequency, and so on.
- R7: A frame with a parity error is dropped. Neither output word nor the byte order changes, no strobe is raised, and err_o is set.
- R8: A frame whose stop bit is sampled low is dropped in the same way and sets err_o. A new frame starts only on a high-to-low transition of the line.
- R9: A low pulse on the line that no longer holds at the middle of the start bit is ignored. It gives no update, no strobe and no error.
- R10: Once set, err_o stays high until reset. freq_upd_o and amp_upd_o are never high together, and an output word changes only in a cycle where its strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Asynchronous serial input; high when idle |
| freq_step_o | output | 16 | Phase step word |
| amp_o | output | 16 | Amplitude word, positive Q15 |
| freq_upd_o | output | 1 | One-cycle pulse when freq_step_o is written |
| amp_upd_o | output | 1 | One-cycle pulse when amp_o is written |
| err_o | output | 1 | Frame error seen since reset; stays set |

## Verification
A good frame updates an output word and its strobe near the middle of the stop bit. That is the sample point plus two synchronizer cycles and one register, well inside the stop bit. The bench therefore reads the words and the error flag only after the whole stop bit and one further idle bit time. By then every result of the frame is settled, and none of the next frame has begun. Strobes are counted on the falling clock edge across each frame, so every frame must give exactly the expected number of one-cycle pulses. Dropped frames and start glitches are checked the same way: zero pulses, and words left unchanged.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

    localparam int OVS       = 16;             // samples per bit
    localparam int OVS_W     = $clog2(OVS);
    localparam int MID_TICK  = OVS / 2 - 1;    // start-bit midpoint
    localparam int LAST_TICK = OVS - 1;        // one full bit later
    localparam int DBITS     = 8;
    localparam int WORD_W    = 16;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef enum logic {
        WANT_FREQ,
        WANT_AMP
    } seq_state_e;

    typedef struct packed {
        logic [DBITS-1:0] data;
        logic             good;
        logic             bad;
    } rx_evt_t;

    function automatic int calc_div(input longint clk_hz, input longint baud);
        longint q;
        q = (clk_hz + (baud * OVS) / 2) / (baud * OVS);
        return (q < 1) ? 1 : int'(q);
    endfunction

    function automatic logic [WORD_W-1:0] amp_word(input logic [DBITS-1:0] b);
        return {1'b0, b, {(WORD_W-DBITS-1){1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] freq_word(input logic [DBITS-1:0] b);
        return {{(WORD_W-DBITS){1'b0}}, b};
    endfunction

endpackage

// File: rtl/sdl_tick_gen.sv
module sdl_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= (cnt == TOP);
            cnt    <= (cnt == TOP) ? '0 : cnt + 1'b1;
        end
    end

    // R2: ticks are isolated pulses when the divisor exceeds one
    generate
        if (DIV > 1) begin : g_chk
            a_r2_tick_single: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/sdl_uart_rx.sv
module sdl_uart_rx
    import sdl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick_i,
    input  logic    rxd_i,
    output rx_evt_t evt_o
);
    logic                     rx_m, rx_s, prev_s;
    rx_state_e                state;
    logic [OVS_W-1:0]         os;
    logic [$clog2(DBITS)-1:0] idx;
    logic [DBITS-1:0]         shreg;
    logic                     par;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_m  <= 1'b1;
            rx_s  <= 1'b1;
        end else begin
            rx_m  <= rxd_i;
            rx_s  <= rx_m;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            os     <= '0;
            idx    <= '0;
            shreg  <= '0;
            par    <= 1'b0;
            prev_s <= 1'b1;
            evt_o  <= '0;
        end else begin
            evt_o.good <= 1'b0;
            evt_o.bad  <= 1'b0;
            if (tick_i) begin
                prev_s <= rx_s;
                case (state)
                    RX_IDLE: begin
                        if (prev_s && !rx_s) begin
                            state <= RX_START;
                            os    <= '0;
                        end
                    end
                    RX_START: begin
                        if (os == OVS_W'(MID_TICK)) begin
                            os  <= '0;
                            idx <= '0;
                            state <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            os <= os + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        os <= os + 1'b1;
                        if (os == OVS_W'(LAST_TICK)) begin
                            shreg <= {rx_s, shreg[DBITS-1:1]};
                            if (idx == $clog2(DBITS)'(DBITS - 1)) state <= RX_PAR;
                            else idx <= idx + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        os <= os + 1'b1;
                        if (os == OVS_W'(LAST_TICK)) begin
                            par   <= rx_s;
                            state <= RX_STOP;
                        end
                    end
                    RX_STOP: begin
                        os <= os + 1'b1;
                        if (os == OVS_W'(LAST_TICK)) begin
                            state      <= RX_IDLE;
                            evt_o.data <= shreg;
                            if (rx_s && (^{shreg, par})) evt_o.good <= 1'b1;
                            else                         evt_o.bad  <= 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R7: a frame ends either good or bad, never both
    a_r7_good_bad_excl: assert property (@(posedge clk) disable iff (rst)
        !(evt_o.good && evt_o.bad));
    // R9: a start bit found high at its midpoint returns to idle
    a_r9_glitch_drop: assert property (@(posedge clk) disable iff (rst)
        (tick_i && state == RX_START && os == OVS_W'(MID_TICK) && rx_s) |=> state == RX_IDLE);
    // R1: frame results appear only when leaving the stop state
    a_r1_evt_from_stop: assert property (@(posedge clk) disable iff (rst)
        (evt_o.good || evt_o.bad) |-> state == RX_IDLE);
endmodule

// File: rtl/sdl_param_seq.sv
module sdl_param_seq
    import sdl_pkg::*;
#(
    parameter logic [WORD_W-1:0] FREQ_RST = 16'd500,
    parameter logic [WORD_W-1:0] AMP_RST  = 16'h7FFF
) (
    input  logic              clk,
    input  logic              rst,
    input  rx_evt_t           evt_i,
    output logic [WORD_W-1:0] freq_o,
    output logic [WORD_W-1:0] amp_o,
    output logic              freq_upd_o,
    output logic              amp_upd_o,
    output logic              err_o
);
    seq_state_e want;

    always_ff @(posedge clk) begin
        if (rst) begin
            want       <= WANT_FREQ;
            freq_o     <= FREQ_RST;
            amp_o      <= AMP_RST;
            freq_upd_o <= 1'b0;
            amp_upd_o  <= 1'b0;
            err_o      <= 1'b0;
        end else begin
            freq_upd_o <= 1'b0;
            amp_upd_o  <= 1'b0;
            if (evt_i.bad) err_o <= 1'b1;
            if (evt_i.good) begin
                if (want == WANT_FREQ) begin
                    freq_o     <= freq_word(evt_i.data);
                    freq_upd_o <= 1'b1;
                    want       <= WANT_AMP;
                end else begin
                    amp_o      <= amp_word(evt_i.data);
                    amp_upd_o  <= 1'b1;
                    want       <= WANT_FREQ;
                end
            end
        end
    end

    // R10: sticky error, exclusive strobes, words change only with strobe
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({freq_upd_o, amp_upd_o}));
    a_r10_freq_quiet: assert property (@(posedge clk) disable iff (rst)
        !$stable(freq_o) |-> freq_upd_o);
    a_r10_amp_quiet: assert property (@(posedge clk) disable iff (rst)
        !$stable(amp_o) |-> amp_upd_o);
    // R4: frequency writes are zero-extended
    a_r4_freq_zext: assert property (@(posedge clk) disable iff (rst)
        freq_upd_o |-> freq_o[WORD_W-1:DBITS] == '0);
    // R5: amplitude writes are positive with clear low bits
    a_r5_amp_shape: assert property (@(posedge clk) disable iff (rst)
        amp_upd_o |-> (amp_o[WORD_W-DBITS-2:0] == '0 && !amp_o[WORD_W-1]));
    // R6: strobes are single-cycle pulses
    a_r6_freq_pulse: assert property (@(posedge clk) disable iff (rst)
        freq_upd_o |=> !freq_upd_o);
    a_r6_amp_pulse: assert property (@(posedge clk) disable iff (rst)
        amp_upd_o |=> !amp_upd_o);
endmodule

// File: rtl/sdl_param_loader.sv
module sdl_param_loader
    import sdl_pkg::*;
#(
    parameter longint            CLK_HZ   = 250_000_000,
    parameter longint            BAUD     = 19_200,
    parameter logic [WORD_W-1:0] FREQ_RST = 16'd500,
    parameter logic [WORD_W-1:0] AMP_RST  = 16'h7FFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd_i,
    output logic [WORD_W-1:0] freq_step_o,
    output logic [WORD_W-1:0] amp_o,
    output logic              freq_upd_o,
    output logic              amp_upd_o,
    output logic              err_o
);
    localparam int DIV = calc_div(CLK_HZ, BAUD);

    logic    tick;
    rx_evt_t evt;

    sdl_tick_gen #(.DIV(DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    sdl_uart_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .rxd_i  (rxd_i),
        .evt_o  (evt)
    );

    sdl_param_seq #(.FREQ_RST(FREQ_RST), .AMP_RST(AMP_RST)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .freq_o     (freq_step_o),
        .amp_o      (amp_o),
        .freq_upd_o (freq_upd_o),
        .amp_upd_o  (amp_upd_o),
        .err_o      (err_o)
    );
endmodule

// File: tb/sim_sdl_param_loader.sv
`timescale 1ns/1ps
module sim_sdl_param_loader;
    localparam longint CLK_HZ = 250_000_000;
    localparam longint BAUD   = 3_906_250;     // DIV = 4 at 250 MHz
    localparam int     DIV    = 4;
    localparam int     BITC   = 16 * DIV;      // R2: cycles per bit

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rxd = 1'b1;
    logic [15:0] freq_step, amp;
    logic        freq_upd, amp_upd, err;

    int checks = 0, failures = 0;
    int n_fu = 0, n_au = 0, n_long = 0;
    logic fu_d = 1'b0, au_d = 1'b0;

    logic [15:0] e_freq, e_amp;
    logic        e_err, e_want_amp;

    always #2 clk = ~clk;

    sdl_param_loader #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u0 (
        .clk(clk), .rst(rst), .rxd_i(rxd),
        .freq_step_o(freq_step), .amp_o(amp),
        .freq_upd_o(freq_upd), .amp_upd_o(amp_upd), .err_o(err)
    );

    always @(negedge clk) begin
        if (freq_upd) n_fu++;
        if (amp_upd)  n_au++;
        if ((freq_upd && fu_d) || (amp_upd && au_d) || (freq_upd && amp_upd)) n_long++;
        fu_d = freq_upd;
        au_d = amp_upd;
    end

    function automatic logic [15:0] m_amp(input logic [7:0] b);
        return {1'b0, b, 7'b0};
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // kind: 0 good, 1 parity flipped, 2 stop bit low
    task automatic send(input logic [7:0] b, input int kind);
        logic p;
        p = ~^b;
        if (kind == 1) p = ~p;
        rxd = 1'b0; wait_cyc(BITC);
        for (int i = 0; i < 8; i++) begin rxd = b[i]; wait_cyc(BITC); end
        rxd = p; wait_cyc(BITC);
        rxd = (kind == 2) ? 1'b0 : 1'b1; wait_cyc(BITC);
        if (kind == 2) wait_cyc(BITC);
        rxd = 1'b1; wait_cyc(BITC);
    endtask

    task automatic frame_check(input string req, input logic [7:0] b, input int kind);
        int f0, a0;
        f0 = n_fu; a0 = n_au;
        send(b, kind);
        if (kind == 0) begin
            if (e_want_amp) e_amp = m_amp(b); else e_freq = {8'h00, b};
            chk({req, " amp upd count"},  n_au - a0, e_want_amp ? 1 : 0);
            chk({req, " freq upd count"}, n_fu - f0, e_want_amp ? 0 : 1);
            e_want_amp = ~e_want_amp;
        end else begin
            e_err = 1'b1;
            chk({req, " no strobe"}, (n_fu - f0) + (n_au - a0), 0);
        end
        chk({req, " freq word"}, freq_step, e_freq);
        chk({req, " amp word"},  amp, e_amp);
        chk({req, " err flag"},  err, e_err);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 190_000; i++) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [7:0] b;
        int f0, a0;
        void'($urandom(32'h5EED_0042));
        wait_cyc(10);
        rst = 1'b0;
        wait_cyc(5);
        e_freq = 16'd500; e_amp = 16'h7FFF; e_err = 1'b0; e_want_amp = 1'b0;
        // R3 reset state
        chk("R3 reset freq", freq_step, 16'd500);
        chk("R3 reset amp",  amp, 16'h7FFF);
        chk("R3 reset err",  err, 0);

        // R1 R2 R4 R5 R6 directed corners
        frame_check("R4 R1 first byte freq", 8'hA5, 0);
        frame_check("R5 R6 second byte amp", 8'hFF, 0);
        frame_check("R4 R6 freq zero",       8'h00, 0);
        frame_check("R5 amp zero",           8'h00, 0);
        frame_check("R4 freq ff",            8'hFF, 0);
        frame_check("R5 amp 01",             8'h01, 0);

        // R1 R2 random good bytes
        for (int k = 0; k < 20; k++) begin
            b = 8'($urandom);
            frame_check("R6 R1 random", b, 0);
        end

        // R9 start glitch shorter than half a bit
        f0 = n_fu; a0 = n_au;
        rxd = 1'b0; wait_cyc(3 * DIV);
        rxd = 1'b1; wait_cyc(3 * BITC);
        chk("R9 glitch no strobe", (n_fu - f0) + (n_au - a0), 0);
        chk("R9 glitch freq",      freq_step, e_freq);
        chk("R9 glitch amp",       amp, e_amp);
        chk("R9 glitch err",       err, 0);

        // R7 parity error: dropped, order kept, err set
        frame_check("R7 parity bad", 8'h3C, 1);
        frame_check("R7 order kept", 8'h77, 0);
        // R10 sticky error stays set across good frames
        frame_check("R10 err sticky", 8'h12, 0);
        // R8 stop bit low
        frame_check("R8 stop low", 8'h81, 2);
        frame_check("R8 order kept", 8'h5A, 0);
        frame_check("R8 R6 next", 8'h6B, 0);

        chk("R10 strobes single and exclusive", n_long, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule